// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block behaves like the digital side of a two-channel sampling converter. It is meant to sit in a host controller's testbench or in an FPGA as a loopback target. A falling edge on the conversion-start input captures two parallel result words, one per channel. The block then signals a conversion in progress for a fixed number of system-clock cycles. After that, it serves both words on two serial data lines. Each line has its own output-enable, which stands in for a three-state pin: an enable at 0 means the line is released.

All three control inputs (conversion start, select, serial clock) are asynchronous to the system clock. Each passes through a synchroniser of `SYNC_STAGES` flops. Edges are found by comparing the synchronised level with its value one cycle earlier. A registered effect therefore shows up `SYNC_STAGES + 1` system-clock cycles after the input changes.

Two state machines do the work.

- **Conversion controller.** It has the states `CV_IDLE` and `CV_BUSY`.
  - `CV_IDLE` moves to `CV_BUSY` on a start fall ("launch"). The result words are latched on this transition.
  - `CV_BUSY` returns to `CV_IDLE` when its cycle counter reaches `CONV_CYCLES-1` ("finish"). During that last cycle it emits a one-cycle done pulse.
- **Reader.** It has the states `RD_OFF`, `RD_WAIT` and `RD_SHIFT`.
  - `RD_OFF` moves to `RD_SHIFT` on a select fall when no conversion is running, or when the conversion is finishing in that cycle ("open"). The two lines are loaded on this transition.
  - `RD_OFF` moves to `RD_WAIT` on a select fall while a conversion is running ("park").
  - `RD_WAIT` moves to `RD_SHIFT` on the done pulse ("release"). The two lines are loaded on this transition.
  - `RD_SHIFT` stays in `RD_SHIFT` and shifts one bit on each serial-clock fall ("step"). On the done pulse it stays in `RD_SHIFT` and reloads both lines ("refresh").
  - Both `RD_WAIT` and `RD_SHIFT` return to `RD_OFF` whenever select is high ("close").

Holding select low all the time gives continuous mode. Each new result then appears on the lines in the same cycle that the busy output drops.

Top module: `sadc_port_model`

## Requirements
- R1: A start-input fall seen in `CV_IDLE` latches `chan_a_i` and `chan_b_i` and raises `conv_active_o` three cycles after the input edge (with `SYNC_STAGES`=2). The output stays high for exactly `CONV_CYCLES` system-clock cycles.
- R2: While select is high, both enables are 0 and both data outputs are 0.
- R3: A select fall while no conversion is running sets both enables to 1. Line A then shows bit `DATA_W-1` of the channel A word, and line B shows bit `DATA_W-1` of the channel B word.
- R4: While select is low, each later serial-clock fall presents the next lower bit of the line's own word.
- R5: After `DATA_W` bits, line A continues with the channel B word and line B continues with the channel A word, MSB first.
- R6: After `2*DATA_W` bits, a line shows 0 on every further serial-clock fall until select rises.
- R7: A serial-clock fall detected in the same cycle as the select fall does not shift. The MSB stays until the next serial-clock fall.
- R8: A select fall during a conversion enables both lines at data 0, and serial-clock falls are ignored. Each line shows its MSB in the first cycle in which `conv_active_o` is low.
- R9: With select held low, the enables never drop. Each conversion reloads both lines so that the new MSBs appear in the same cycle that `conv_active_o` falls.
- R10: A start-input fall while a conversion is running is ignored. The words latched at launch are the ones served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n_i | input | 1 | Conversion start; the falling edge launches a conversion |
| chan_a_i | input | DATA_W | Channel A parallel result |
| chan_b_i | input | DATA_W | Channel B parallel result |
| sel_n_i | input | 1 | Active-low select for the serial read |
| sck_i | input | 1 | Serial clock; falling edges advance the bit |
| conv_active_o | output | 1 | High while a conversion is in progress |
| sdata_a_o | output | 1 | Serial data, line A |
| sdata_a_en_o | output | 1 | Drive enable for line A (0 = released) |
| sdata_b_o | output | 1 | Serial data, line B |
| sdata_b_en_o | output | 1 | Drive enable for line B (0 = released) |

## Verification
The assertions assume that the result inputs do not change in the cycle the start fall is detected. They also assume that each control input holds its level for at least `SYNC_STAGES + 1` cycles, so that every edge is seen exactly once. The stimulus meets both assumptions:

- Every input change is made at the falling clock edge.
- Each serial-clock and select level is held for four cycles.
- The result inputs are changed only well after the launch.

The sweep uses a 6-bit word with a 12-cycle conversion. It covers several computed word pairs, all-ones and all-zeros pairs, coincident select and serial-clock falls, early select, a retrigger during a conversion, and continuous mode.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    typedef enum logic {
        CV_IDLE,
        CV_BUSY
    } conv_state_t;

    typedef enum logic [1:0] {
        RD_OFF,
        RD_WAIT,
        RD_SHIFT
    } rd_state_t;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sadc_conv_ctrl.sv
module sadc_conv_ctrl
    import sadc_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_fall,
    input  logic [DATA_W-1:0] res_a,
    input  logic [DATA_W-1:0] res_b,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] word_a,
    output logic [DATA_W-1:0] word_b
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    conv_state_t       cv_q, cv_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] word_a_q, word_b_q;
    logic              launch;

    always_comb begin
        cv_d   = cv_q;
        launch = 1'b0;
        unique case (cv_q)
            CV_IDLE: if (start_fall) begin
                launch = 1'b1;
                cv_d   = CV_BUSY;
            end
            CV_BUSY: if (cnt_q == LAST) cv_d = CV_IDLE;
            default: cv_d = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cv_q     <= CV_IDLE;
            cnt_q    <= '0;
            word_a_q <= '0;
            word_b_q <= '0;
        end else begin
            cv_q <= cv_d;
            if (launch) begin
                cnt_q    <= '0;
                word_a_q <= res_a;
                word_b_q <= res_b;
            end else if (cv_q == CV_BUSY) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy   = (cv_q == CV_BUSY);
        done   = (cv_q == CV_BUSY) && (cnt_q == LAST);
        word_a = word_a_q;
        word_b = word_b_q;
    end

    // R1: busy only rises after a detected start fall
    assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_fall));

    // R1: the words served are the inputs present at the launch
    assert_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (word_a_q == $past(res_a)) && (word_b_q == $past(res_b)));

    // R10: a start fall during a conversion leaves the words untouched
    assert_retrigger_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start_fall |=> $stable(word_a_q) && $stable(word_b_q));
endmodule

// File: rtl/sadc_lane.sv
module sadc_lane #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] first_word,
    input  logic [DATA_W-1:0] second_word,
    output logic              msb
);
    localparam int SR_W = 2 * DATA_W;

    logic [SR_W-1:0] sreg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     sreg_q <= '0;
        else if (load)  sreg_q <= {first_word, second_word};
        else if (shift) sreg_q <= {sreg_q[SR_W-2:0], 1'b0};
    end

    assign msb = sreg_q[SR_W-1];
endmodule

// File: rtl/sadc_port_model.sv
module sadc_port_model
    import sadc_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CONV_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n_i,
    input  logic [DATA_W-1:0] chan_a_i,
    input  logic [DATA_W-1:0] chan_b_i,
    input  logic              sel_n_i,
    input  logic              sck_i,
    output logic              conv_active_o,
    output logic              sdata_a_o,
    output logic              sdata_a_en_o,
    output logic              sdata_b_o,
    output logic              sdata_b_en_o
);
    localparam int N_IN  = 3;
    localparam int N_LN  = 2;

    logic [N_IN-1:0] raw_v, lvl_v, prev_q, fall_v;
    logic start_fall, sel_fall, sck_fall, sel_lvl;

    assign raw_v = {sck_i, sel_n_i, start_n_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        sadc_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_v[g]),
            .dout (lvl_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl_v;
    end

    assign fall_v     = prev_q & ~lvl_v;
    assign start_fall = fall_v[0];
    assign sel_fall   = fall_v[1];
    assign sck_fall   = fall_v[2];
    assign sel_lvl    = lvl_v[1];

    logic              conv_busy, conv_done;
    logic [DATA_W-1:0] word_a, word_b;

    sadc_conv_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_fall(start_fall),
        .res_a     (chan_a_i),
        .res_b     (chan_b_i),
        .busy      (conv_busy),
        .done      (conv_done),
        .word_a    (word_a),
        .word_b    (word_b)
    );

    rd_state_t rd_q, rd_d;
    logic      lane_load, lane_shift;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= RD_OFF;
        else        rd_q <= rd_d;
    end

    always_comb begin
        rd_d       = rd_q;
        lane_load  = 1'b0;
        lane_shift = 1'b0;
        unique case (rd_q)
            RD_OFF: if (sel_fall) begin
                if (conv_busy && !conv_done) begin
                    rd_d = RD_WAIT;
                end else begin
                    lane_load = 1'b1;
                    rd_d      = RD_SHIFT;
                end
            end
            RD_WAIT: begin
                if (sel_lvl) begin
                    rd_d = RD_OFF;
                end else if (conv_done) begin
                    lane_load = 1'b1;
                    rd_d      = RD_SHIFT;
                end
            end
            RD_SHIFT: begin
                if (sel_lvl)        rd_d       = RD_OFF;
                else if (conv_done) lane_load  = 1'b1;
                else if (sck_fall)  lane_shift = 1'b1;
            end
            default: rd_d = RD_OFF;
        endcase
    end

    logic [DATA_W-1:0] word_v [N_LN];
    logic [N_LN-1:0]   msb_v;

    assign word_v[0] = word_a;
    assign word_v[1] = word_b;

    for (genvar g = 0; g < N_LN; g++) begin : g_lane
        sadc_lane #(.DATA_W(DATA_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (lane_load),
            .shift      (lane_shift),
            .first_word (word_v[g]),
            .second_word(word_v[N_LN-1-g]),
            .msb        (msb_v[g])
        );
    end

    always_comb begin
        conv_active_o = conv_busy;
        sdata_a_en_o  = (rd_q != RD_OFF);
        sdata_b_en_o  = (rd_q != RD_OFF);
        sdata_a_o     = (rd_q == RD_SHIFT) && msb_v[0];
        sdata_b_o     = (rd_q == RD_SHIFT) && msb_v[1];
    end

    // R2: a high select releases both lines by the next cycle
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lvl |=> !sdata_a_en_o && !sdata_b_en_o);

    // R2: a released line carries no data
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_a_en_o |-> !sdata_a_o && !sdata_b_o);

    // R7: a serial-clock fall together with the select fall does not shift
    assert_coincident_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q == RD_OFF) && sel_fall && sck_fall && !conv_busy && !start_fall
        |=> (sdata_a_o == word_a[DATA_W-1]) && (sdata_b_o == word_b[DATA_W-1]));

    // R8, R9: the conversion end puts the new MSB on an open line
    assert_msb_on_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && (rd_q != RD_OFF) && !sel_lvl
        |=> (sdata_a_o == word_a[DATA_W-1]) && (sdata_b_o == word_b[DATA_W-1]));
endmodule

// File: tb/sim_sadc_port_model.sv
module sim_sadc_port_model;
    localparam int TN = 6;
    localparam int TC = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, start_n, sel_n, sck;
    logic [TN-1:0] ca, cb;
    logic          busy, da, da_en, db, db_en;

    sadc_port_model #(.DATA_W(TN), .CONV_CYCLES(TC), .SYNC_STAGES(2)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_n_i    (start_n),
        .chan_a_i     (ca),
        .chan_b_i     (cb),
        .sel_n_i      (sel_n),
        .sck_i        (sck),
        .conv_active_o(busy),
        .sdata_a_o    (da),
        .sdata_a_en_o (da_en),
        .sdata_b_o    (db),
        .sdata_b_en_o (db_en)
    );

    int checks = 0;
    int fails  = 0;
    logic fall_a, fall_b;
    bit   en_dropped;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic ebit(logic [TN-1:0] x, logic [TN-1:0] y, int k);
        if (k < TN)          return x[TN-1-k];
        else if (k < 2 * TN) return y[2*TN-1-k];
        else                 return 1'b0;
    endfunction

    // Launch a conversion; record line values in the first cycle busy is low.
    task automatic do_conv(logic [TN-1:0] a, logic [TN-1:0] b, bit retrig, bit early);
        int  busy_cnt = 0;
        bit  seen = 0;
        ca = a; cb = b; start_n = 1'b0; en_dropped = 0;
        for (int c = 1; c < 200; c++) begin
            @(negedge clk);
            if (!sel_n && !early && !da_en) en_dropped = 1;
            if (busy) begin
                busy_cnt++;
                seen = 1;
            end else if (seen) begin
                fall_a = da; fall_b = db;
                break;
            end
            if (c == 2) start_n = 1'b1;
            if (c == 4) begin ca = ~a; cb = ~b; end
            if (retrig && c == 6) start_n = 1'b0;
            if (retrig && c == 8) start_n = 1'b1;
            if (early && c == 5) sel_n = 1'b0;
            if (early && c == 10) begin
                chk(da_en && db_en, "R8 enables during wait", {da_en, db_en}, 2'b11);
                chk(!da && !db, "R8 data zero during wait", {da, db}, 0);
                chk(busy, "R8 still converting", busy, 1);
                sck = 1'b0;
            end
            if (early && c == 12) sck = 1'b1;
        end
        chk(busy_cnt == TC, "R1 busy length", busy_cnt, TC);
    endtask

    task automatic read_frame(logic [TN-1:0] a, logic [TN-1:0] b, bit coinc);
        sel_n = 1'b0;
        if (coinc) sck = 1'b0;
        step(4);
        chk(da_en && db_en, "R3 enables", {da_en, db_en}, 2'b11);
        chk(da == a[TN-1], "R3 line A msb", da, a[TN-1]);
        chk(db == b[TN-1], "R3 line B msb", db, b[TN-1]);
        if (coinc) begin
            sck = 1'b1;
            step(4);
            chk(da == a[TN-1] && db == b[TN-1], "R7 msb held",
                {da, db}, {a[TN-1], b[TN-1]});
        end
        for (int k = 1; k < 2 * TN + 3; k++) begin
            logic ea, eb;
            string tag;
            sck = 1'b0;
            step(4);
            ea = ebit(a, b, k);
            eb = ebit(b, a, k);
            tag = (k < TN) ? "R4 own word" : (k < 2 * TN) ? "R5 chained word" : "R6 zero fill";
            chk(da == ea, {tag, " line A"}, da, ea);
            chk(db == eb, {tag, " line B"}, db, eb);
            sck = 1'b1;
            step(4);
        end
        sel_n = 1'b1;
        step(4);
        chk(!da_en && !db_en && !da && !db, "R2 released",
            {da_en, db_en, da, db}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [TN-1:0] a, b;
        rst_n = 1'b0; start_n = 1'b1; sel_n = 1'b1; sck = 1'b1; ca = '0; cb = '0;
        step(5);
        rst_n = 1'b1;
        step(2);
        chk(!busy, "R1 idle after reset", busy, 0);
        chk(!da_en && !db_en && !da && !db, "R2 reset state", {da_en, db_en, da, db}, 0);

        // Sweep of computed word pairs, odd rounds with coincident edges (R7)
        for (int i = 0; i < 16; i++) begin
            a = TN'((i * 11 + 5) % 64);
            b = TN'((i * 37 + 60) % 64);
            do_conv(a, b, 0, 0);
            read_frame(a, b, (i % 2) == 1);
        end
        do_conv('1, '0, 0, 0);
        read_frame('1, '0, 1);
        do_conv('0, '1, 0, 0);
        read_frame('0, '1, 0);

        // R10: retrigger during a conversion is ignored
        do_conv(6'h2d, 6'h12, 1, 0);
        read_frame(6'h2d, 6'h12, 0);

        // R8: select falls while converting
        do_conv(6'h35, 6'h0a, 0, 1);
        chk(fall_a == 1'b1 && fall_b == 1'b0, "R8 msb at busy fall", {fall_a, fall_b}, 2'b10);
        sck = 1'b0; step(4);
        chk(da == 1'b1 && db == 1'b0, "R8 first shift", {da, db}, 2'b10);
        sck = 1'b1; step(4);
        sel_n = 1'b1; step(4);

        // R9: continuous mode, select held low across two conversions
        sel_n = 1'b0; step(4);
        do_conv(6'h2a, 6'h15, 0, 0);
        chk(fall_a == 1'b1 && fall_b == 1'b0, "R9 msb at busy fall 1", {fall_a, fall_b}, 2'b10);
        chk(!en_dropped, "R9 enable held 1", en_dropped, 0);
        for (int k = 1; k < 3; k++) begin
            sck = 1'b0; step(4);
            chk(da == ebit(6'h2a, 6'h15, k) && db == ebit(6'h15, 6'h2a, k), "R9 bits",
                {da, db}, {ebit(6'h2a, 6'h15, k), ebit(6'h15, 6'h2a, k)});
            sck = 1'b1; step(4);
        end
        do_conv(6'h11, 6'h3e, 0, 0);
        chk(fall_a == 1'b0 && fall_b == 1'b1, "R9 msb at busy fall 2", {fall_a, fall_b}, 2'b01);
        chk(!en_dropped, "R9 enable held 2", en_dropped, 0);
        sck = 1'b0; step(4);
        chk(da == 1'b1 && db == 1'b1, "R9 reload bit 1", {da, db}, 2'b11);
        sck = 1'b1; step(4);
        sel_n = 1'b1; step(4);
        chk(!da_en && !db_en, "R2 release after continuous", {da_en, db_en}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule